// File: doc/BRIEF.md
# Error Frame Sequencer for an Error-Active Bus Node

This block produces the error frame that a CAN node sends while it is error-active, and it keeps the receive error count that goes with that frame. The surrounding controller gives it three things: a strobe that is high for one clock at each bit time, the sampled bus level, and a pulse when the controller detects an error. The block then drives the transmit line. It holds the line dominant for a fixed-length flag. It then releases the line and watches the bus until the dominant run that other nodes superpose has ended. Last, it counts out the recessive delimiter and reports completion.

The block also owns the receive error counter, which other logic can bump by one. The block itself adds the eight-point penalty when the node was receiving and the bus is still dominant in the first bit that follows its own flag. The counter saturates rather than wrapping, and it can be cleared. A sticky warning is raised if the dominant run lasts longer than the longest run that legal superposition can produce.

Top module: `can_err_frame_seq`

## Requirements
- R1: After synchronous reset, tx_bit is 1 (recessive), phase_o is 0 (idle), done is 0, overrun is 0 and rec_cnt is 0. Dominant is 0 and recessive is 1 on tx_bit and rx_bit.
- R2: A bit-time strobe with err_det high while idle starts a sequence. Phase_o becomes 1 (flag) and tx_bit is 0 for exactly six bit times. The bus is sampled at the end of each bit time.
- R3: From the sixth flag strobe on, tx_bit is 1 and phase_o is 2 (waiting). The block stays there while rx_bit is sampled 0, so any total dominant run of 6 to 12 bits is accepted.
- R4: The first strobe that samples rx_bit as 1 while waiting moves phase_o to 3 (delimiter). The seventh strobe after that raises done for exactly one clock, together with phase_o 0 and tx_bit 1. The delimiter is therefore eight recessive bits.
- R5: If the role latched at the start is receiver (is_receiver 1) and rx_bit is sampled 0 at the seventh bit from the flag start, rec_cnt rises by 8.
- R6: Dominant bits sampled after the seventh bit add no further penalty. The transmitter role (is_receiver 0, latched at the start strobe) never takes the penalty.
- R7: If rx_bit is sampled 0 while waiting at the thirteenth bit from the flag start or later, overrun goes to 1 and stays 1 until reset. The block keeps waiting for recessive and completes normally.
- R8: err_det while a sequence is in progress has no effect on the flag length, the phases or the completion time.
- R9: rec_inc adds 1 in the clock it is high. If it coincides with the penalty, the count rises by 9. The count saturates at 255.
- R10: rec_clr sets rec_cnt to 0 in the next clock and takes priority over rec_inc and the penalty.
- R11: phase_o and tx_bit change only after a clock in which bit_tick is high. err_det without the strobe starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level, 0 dominant |
| err_det | input | 1 | Error detected by the controller |
| is_receiver | input | 1 | Node role at error time, 1 receiver |
| rec_inc | input | 1 | External +1 request for the receive count |
| rec_clr | input | 1 | Clear the receive count |
| tx_bit | output | 1 | Transmit level, 0 dominant |
| phase_o | output | 2 | 0 idle, 1 flag, 2 waiting, 3 delimiter |
| done | output | 1 | One-clock completion pulse |
| overrun | output | 1 | Sticky over-long dominant run warning |
| rec_cnt | output | CNT_W | Receive error count |

## Verification
Two things can land on the receive count in the same clock: the block's own penalty, which is decided on the seventh-bit strobe, and the external increment. The bench raises rec_inc exactly on that strobe and expects one combined rise of nine. A later frame repeats this with the count already at 255 and expects the count to stay at 255. The clear is also asserted together with rec_inc, and the bench expects zero, which shows the clear wins.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FLAG  = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DELIM = 2'd3
  } ef_phase_t;

  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

endpackage

// File: rtl/can_ef_bitpos.sv
// Bit index counter: loads 1, advances per bit, saturates at MAXV.
module can_ef_bitpos #(
  parameter int MAXV = 13,
  parameter int W    = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] TOP = W'(MAXV);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (load) begin
      pos <= ONE;
    end else if (adv && pos != TOP) begin
      pos <= pos + ONE;
    end
  end
endmodule

// File: rtl/can_ef_errcnt.sv
// Saturating receive error counter with clear priority.
module can_ef_errcnt #(
  parameter int W   = 8,
  parameter int PEN = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         pen,
  output logic [W-1:0] cnt
);
  localparam int SUM_W = W + $clog2(PEN + 2) + 1;
  localparam logic [W-1:0]     CNT_MAX = '1;
  localparam logic [SUM_W-1:0] SUM_CAP = SUM_W'(CNT_MAX);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(cnt) + SUM_W'(inc);
    if (pen) sum = sum + SUM_W'(PEN);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (sum > SUM_CAP) begin
      cnt <= CNT_MAX;
    end else begin
      cnt <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/can_ef_fsm.sv
// Phase sequencer: flag, wait for recessive, delimiter.
module can_ef_fsm
  import can_ef_pkg::*;
#(
  parameter int FLAG_LEN    = 6,
  parameter int DELIM_EXTRA = 7,
  parameter int MAX_DOM     = 12,
  parameter int POS_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             rx_bit,
  input  logic             err_det,
  input  logic             is_receiver,
  input  logic [POS_W-1:0] pos,
  output logic             pos_load,
  output logic             pos_adv,
  output logic             pen,
  output ef_phase_t        phase,
  output logic             tx_bit,
  output logic             done,
  output logic             overrun
);
  localparam logic [POS_W-1:0] FLAG_LAST   = POS_W'(FLAG_LEN);
  localparam logic [POS_W-1:0] FIRST_AFTER = POS_W'(FLAG_LEN + 1);
  localparam logic [POS_W-1:0] RUN_LIMIT   = POS_W'(MAX_DOM);
  localparam logic [POS_W-1:0] DELIM_LAST  = POS_W'(DELIM_EXTRA);

  ef_phase_t state_d;
  logic      rcv_q;
  logic      set_ovr;
  logic      fin;

  always_comb begin
    state_d  = phase;
    pos_load = 1'b0;
    pos_adv  = 1'b0;
    pen      = 1'b0;
    set_ovr  = 1'b0;
    fin      = 1'b0;
    if (bit_tick) begin
      unique case (phase)
        PH_IDLE: begin
          if (err_det) begin
            state_d  = PH_FLAG;
            pos_load = 1'b1;
          end
        end
        PH_FLAG: begin
          pos_adv = 1'b1;
          if (pos == FLAG_LAST) state_d = PH_WAIT;
        end
        PH_WAIT: begin
          if (rx_bit == LVL_REC) begin
            state_d  = PH_DELIM;
            pos_load = 1'b1;
          end else begin
            pos_adv = 1'b1;
            if (pos == FIRST_AFTER && rcv_q) pen = 1'b1;
            if (pos > RUN_LIMIT) set_ovr = 1'b1;
          end
        end
        PH_DELIM: begin
          if (pos == DELIM_LAST) begin
            state_d = PH_IDLE;
            fin     = 1'b1;
          end else begin
            pos_adv = 1'b1;
          end
        end
        default: state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      rcv_q   <= 1'b0;
      tx_bit  <= LVL_REC;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      phase  <= state_d;
      tx_bit <= (state_d == PH_FLAG) ? LVL_DOM : LVL_REC;
      done   <= fin;
      if (set_ovr) overrun <= 1'b1;
      if (phase == PH_IDLE && state_d == PH_FLAG) rcv_q <= is_receiver;
    end
  end
endmodule

// File: rtl/can_err_frame_seq.sv
module can_err_frame_seq
  import can_ef_pkg::*;
#(
  parameter int FLAG_LEN    = 6,
  parameter int DELIM_EXTRA = 7,
  parameter int MAX_DOM     = 12,
  parameter int CNT_W       = 8,
  parameter int PENALTY     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             rx_bit,
  input  logic             err_det,
  input  logic             is_receiver,
  input  logic             rec_inc,
  input  logic             rec_clr,
  output logic             tx_bit,
  output logic [1:0]       phase_o,
  output logic             done,
  output logic             overrun,
  output logic [CNT_W-1:0] rec_cnt
);
  localparam int POS_MAX = (MAX_DOM + 1 > DELIM_EXTRA) ? MAX_DOM + 1 : DELIM_EXTRA;
  localparam int POS_W   = $clog2(POS_MAX + 1);

  logic [POS_W-1:0] pos;
  logic             pos_load;
  logic             pos_adv;
  logic             pen;
  ef_phase_t        phase;

  can_ef_bitpos #(.MAXV(POS_MAX), .W(POS_W)) u_pos (
    .clk  (clk),
    .rst  (rst),
    .load (pos_load),
    .adv  (pos_adv),
    .pos  (pos)
  );

  can_ef_fsm #(
    .FLAG_LEN    (FLAG_LEN),
    .DELIM_EXTRA (DELIM_EXTRA),
    .MAX_DOM     (MAX_DOM),
    .POS_W       (POS_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .rx_bit      (rx_bit),
    .err_det     (err_det),
    .is_receiver (is_receiver),
    .pos         (pos),
    .pos_load    (pos_load),
    .pos_adv     (pos_adv),
    .pen         (pen),
    .phase       (phase),
    .tx_bit      (tx_bit),
    .done        (done),
    .overrun     (overrun)
  );

  can_ef_errcnt #(.W(CNT_W), .PEN(PENALTY)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (rec_clr),
    .inc (rec_inc),
    .pen (pen),
    .cnt (rec_cnt)
  );

  assign phase_o = phase;
endmodule

// File: rtl/can_ef_chk.sv
module can_ef_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_tick,
  input logic             rec_clr,
  input logic             tx_bit,
  input logic [1:0]       phase_o,
  input logic             done,
  input logic             overrun,
  input logic [CNT_W-1:0] rec_cnt
);
  localparam logic [CNT_W-1:0] FULL = '1;

  a_r2_flag_dominant: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd1) |-> (tx_bit == 1'b0));

  a_r3_recessive_elsewhere: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd1) |-> (tx_bit == 1'b1));

  a_r4_done_one_clock: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_after_delim: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (phase_o == 2'd0 && $past(phase_o) == 2'd3));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (rec_cnt == FULL && !rec_clr) |=> (rec_cnt == FULL));

  a_r9_no_decrease: assert property (@(posedge clk) disable iff (rst)
    !rec_clr |=> (rec_cnt >= $past(rec_cnt)));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    rec_clr |=> (rec_cnt == '0));

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> ($stable(phase_o) && $stable(tx_bit)));
endmodule

bind can_err_frame_seq can_ef_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_tick (bit_tick),
  .rec_clr  (rec_clr),
  .tx_bit   (tx_bit),
  .phase_o  (phase_o),
  .done     (done),
  .overrun  (overrun),
  .rec_cnt  (rec_cnt)
);

// File: tb/can_err_frame_seq_test.sv
module can_err_frame_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       bit_tick = 1'b0, rx_bit = 1'b1, err_det = 1'b0;
  logic       is_receiver = 1'b1, rec_inc = 1'b0, rec_clr = 1'b0;
  logic       tx_bit, done, overrun;
  logic [1:0] phase_o;
  logic [7:0] rec_cnt;

  int total = 0, bad = 0, exp_rec = 0, exp_ovr = 0;
  bit finished = 0;

  can_err_frame_seq uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit), .err_det(err_det),
    .is_receiver(is_receiver), .rec_inc(rec_inc), .rec_clr(rec_clr),
    .tx_bit(tx_bit), .phase_o(phase_o), .done(done), .overrun(overrun), .rec_cnt(rec_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_tick(input logic rx, input logic det, input logic inc);
    @(negedge clk);
    rx_bit = rx; err_det = det; rec_inc = inc; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; err_det = 1'b0; rec_inc = 1'b0; rx_bit = 1'b1;
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  // recv: role; ndom: dominant bits after own flag; poke: err_det while busy;
  // inc7: external increment on the bit-7 strobe; stall: strobe-free cycles in flag
  task automatic run_frame(input bit recv, input int ndom, input bit poke,
                           input bit inc7, input bit stall);
    is_receiver = recv;
    do_tick(1'b1, 1'b1, 1'b0);
    chk("R2", "phase at start", phase_o, 1);
    chk("R2", "tx at start", tx_bit, 0);
    if (stall) begin
      is_receiver = ~recv;  // role is latched at the start strobe
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); rx_bit = 1'b0; err_det = 1'b1;
      end
      @(negedge clk); err_det = 1'b0; rx_bit = 1'b1;
      chk("R11", "phase held without strobe", phase_o, 1);
      chk("R11", "tx held without strobe", tx_bit, 0);
    end
    for (int i = 1; i <= 6; i++) begin
      do_tick(1'b0, poke && i == 3, 1'b0);
      if (i < 6) begin
        chk("R2", "flag phase", phase_o, 1);
        chk("R2", "flag tx", tx_bit, 0);
      end else begin
        chk("R3", "wait phase after flag", phase_o, 2);
        chk("R3", "tx released", tx_bit, 1);
      end
    end
    for (int j = 0; j < ndom; j++) begin
      do_tick(1'b0, poke && j == 1, inc7 && j == 0);
      chk("R3", "still waiting on dominant", phase_o, 2);
    end
    do_tick(1'b1, 1'b0, inc7 && ndom == 0);
    chk("R4", "delimiter entered", phase_o, 3);
    for (int k = 1; k <= 7; k++) begin
      do_tick(1'b1, poke && k == 2, 1'b0);
      if (k < 7) begin
        chk("R4", "delimiter phase", phase_o, 3);
        chk("R4", "no early done", done, 0);
      end else begin
        chk("R4", "done pulse", done, 1);
        chk("R4", "idle after done", phase_o, 0);
        chk("R4", "tx recessive at end", tx_bit, 1);
      end
    end
    exp_rec = sat(exp_rec + ((recv && ndom >= 1) ? 8 : 0) + (inc7 ? 1 : 0));
    if (ndom >= 7) exp_ovr = 1;
    chk(recv ? "R5" : "R6", "rec count after frame", rec_cnt, exp_rec);
    chk("R7", "overrun flag", overrun, exp_ovr);
    @(negedge clk);
    chk("R4", "done one clock only", done, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_rec = 0; exp_ovr = 0;
    chk("R1", "tx", tx_bit, 1);
    chk("R1", "phase", phase_o, 0);
    chk("R1", "done", done, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "rec", rec_cnt, 0);
  endtask

  task automatic t_no_start_without_tick();
    @(negedge clk); err_det = 1'b1;
    @(negedge clk); err_det = 1'b0;
    @(negedge clk);
    chk("R11", "no start without strobe", phase_o, 0);
    chk("R11", "tx idle", tx_bit, 1);
  endtask

  task automatic t_inc_alone();
    @(negedge clk); rec_inc = 1'b1;
    @(negedge clk); rec_inc = 1'b0;
    exp_rec = sat(exp_rec + 1);
    chk("R9", "single increment", rec_cnt, exp_rec);
  endtask

  task automatic t_saturate_and_clear();
    @(negedge clk); rec_inc = 1'b1;
    repeat (300) @(negedge clk);
    rec_inc = 1'b0;
    exp_rec = 255;
    chk("R9", "saturated", rec_cnt, 255);
    run_frame(1'b1, 1, 1'b0, 1'b1, 1'b0);
    chk("R9", "stays at max with penalty and increment", rec_cnt, 255);
    @(negedge clk); rec_clr = 1'b1; rec_inc = 1'b1;
    @(negedge clk); rec_clr = 1'b0; rec_inc = 1'b0;
    exp_rec = 0;
    chk("R10", "clear beats increment", rec_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    wrap_up();
  end

  initial begin
    t_reset();
    run_frame(1'b1, 0, 1'b0, 1'b0, 1'b0);   // R5: recessive at bit 7, no penalty
    run_frame(1'b1, 1, 1'b0, 1'b0, 1'b0);   // R5: +8
    run_frame(1'b1, 6, 1'b0, 1'b0, 1'b0);   // R6: 12-bit run, one penalty, no overrun
    run_frame(1'b0, 3, 1'b0, 1'b0, 1'b0);   // R6: transmitter role
    run_frame(1'b1, 2, 1'b1, 1'b0, 1'b0);   // R8: err_det while busy
    run_frame(1'b1, 1, 1'b0, 1'b1, 1'b0);   // R9: +9 in one clock
    t_inc_alone();
    t_no_start_without_tick();
    run_frame(1'b1, 1, 1'b0, 1'b0, 1'b1);   // R11 stall, role latched
    t_saturate_and_clear();
    run_frame(1'b1, 8, 1'b0, 1'b0, 1'b0);   // R7: overrun raised, completes
    run_frame(1'b1, 0, 1'b0, 1'b0, 1'b0);   // R7: overrun sticky
    t_reset();
    wrap_up();
  end
endmodule